// File: doc/BRIEF.md
# Pixel Mean-Scale Normalizer

This block prepares camera pixels for a quantized neural-network engine. Each beat on its input stream carries one pixel as three unsigned 8-bit components. For every component the block removes a per-channel offset, applies a per-channel gain and a power-of-two factor, and clamps the result to a signed byte. The three bytes leave on an output stream in reversed channel order. All arithmetic uses fixed-point constants.

Software first writes the offsets, gains, exponent and frame size through a small write-only register port while the block is idle. A start pulse copies these values into working registers that stay fixed for one frame. The block then accepts exactly width×height pixels and returns the same number of results through a four-stage pipeline. When the output side deasserts ready, every stage holds its contents. A one-cycle done pulse follows the last result.

Top module: `pix_norm_top`

## Requirements
- R1: After reset, out_valid, in_ready and done are all 0, and in_ready stays 0 until a start pulse.
- R2: Each component result is trunc0(((2·p − m) · s · 2^f) / 2^17). Here p is the pixel, m is the 9-bit mean code (mean value m/2), s is the 17-bit gain code (gain value s/65536) and f is the 3-bit exponent (legal range 1 to 7). trunc0 rounds toward zero.
- R3: A result above 127 is output as 127 and a result below −128 is output as −128. The output is two's complement.
- R4: On the input, in_data[7:0] is B, [15:8] is G and [23:16] is R. On the output, out_data[7:0] is the R result, [15:8] the G result and [23:16] the B result. Channel index 0 is B, 1 is G and 2 is R.
- R5: A write with cfg_we=1 sets a register selected by cfg_addr. Addresses 0, 1 and 2 take the mean codes for B, G and R, using cfg_wdata[8:0]. Addresses 3, 4 and 5 take the gain codes for B, G and R, using cfg_wdata[16:0]. Address 6 takes the exponent from cfg_wdata[2:0]. Address 7 takes the width and address 8 the height, both from cfg_wdata[11:0]. A write made during a frame is ignored.
- R6: A start pulse while idle latches all registers for the whole frame. A start pulse during a frame has no effect.
- R7: While out_ready is held at 1, a pixel accepted at one clock edge gives out_valid=1 with its result after the fourth clock edge.
- R8: While out_valid=1 and out_ready=0, out_valid and out_data hold their values. No result is lost or repeated.
- R9: in_ready is 0 once width×height pixels of the frame have been accepted.
- R10: done is high for exactly one cycle, in the cycle after the transfer of the width×height-th result, and the block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register select |
| cfg_wdata | input | 17 | Register write data |
| start | input | 1 | Frame start pulse |
| done | output | 1 | Frame complete pulse |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 24 | Input pixel, B in the low byte |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream can take the result |
| out_data | output | 24 | Result, R in the low byte |

## Verification
Random pixels with the offset-only settings (gain 1.0, small exponent) check the subtraction path and the byte reversal. Pixels of only 0 and 255 with exponent 7 drive every channel into both clamps, which isolates the saturation logic. The half-range offset with gain 1/127.5 combined with fixed pixels that give negative fractional products tells truncation toward zero apart from flooring. Random valid and ready gaps, a register write and a start pulse issued mid-frame, and random per-frame settings check stall behaviour, frame isolation and exponent handling against a model computed in the bench.

// File: rtl/pix_norm_pkg.sv
package pix_norm_pkg;
    localparam int NCH        = 3;
    localparam int PIX_W      = 8;
    localparam int MEAN_W     = PIX_W + 1;
    localparam int SCALE_FRAC = 16;
    localparam int SCALE_W    = SCALE_FRAC + 1;
    localparam int FP_W       = 3;
    localparam int CFG_AW     = 4;
    localparam int CFG_DW     = SCALE_W;
    localparam int STAGES     = 4;
    localparam int DIFF_W     = PIX_W + 2;
    localparam int PROD_W     = DIFF_W + SCALE_W + 1;
    localparam int SHIFT_W    = PROD_W + (1 << FP_W) - 1;
    localparam int DROP       = SCALE_FRAC + 1;
    localparam int QUO_W      = SHIFT_W - DROP;

    typedef enum logic [CFG_AW-1:0] {
        A_MEAN_B = 4'd0, A_MEAN_G = 4'd1, A_MEAN_R = 4'd2,
        A_SCL_B  = 4'd3, A_SCL_G  = 4'd4, A_SCL_R  = 4'd5,
        A_FIXPOS = 4'd6, A_WIDTH  = 4'd7, A_HEIGHT = 4'd8
    } cfg_addr_e;
endpackage

// File: rtl/pix_norm_cfg.sv
module pix_norm_cfg
    import pix_norm_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           busy,
    input  logic                           launch,
    input  logic                           cfg_we,
    input  logic [CFG_AW-1:0]              cfg_addr,
    input  logic [CFG_DW-1:0]              cfg_wdata,
    output logic [NCH-1:0][MEAN_W-1:0]     act_mean,
    output logic [NCH-1:0][SCALE_W-1:0]    act_scale,
    output logic [FP_W-1:0]                act_fp,
    output logic [DIM_W-1:0]               act_w,
    output logic [DIM_W-1:0]               act_h
);
    typedef struct packed {
        logic [NCH-1:0][MEAN_W-1:0]  mean;
        logic [NCH-1:0][SCALE_W-1:0] scale;
        logic [FP_W-1:0]             fp;
        logic [DIM_W-1:0]            w;
        logic [DIM_W-1:0]            h;
    } regs_t;

    typedef struct packed {
        regs_t shd;
        regs_t act;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we && !busy) begin
            case (cfg_addr)
                A_MEAN_B: s_d.shd.mean[0]  = cfg_wdata[MEAN_W-1:0];
                A_MEAN_G: s_d.shd.mean[1]  = cfg_wdata[MEAN_W-1:0];
                A_MEAN_R: s_d.shd.mean[2]  = cfg_wdata[MEAN_W-1:0];
                A_SCL_B:  s_d.shd.scale[0] = cfg_wdata[SCALE_W-1:0];
                A_SCL_G:  s_d.shd.scale[1] = cfg_wdata[SCALE_W-1:0];
                A_SCL_R:  s_d.shd.scale[2] = cfg_wdata[SCALE_W-1:0];
                A_FIXPOS: s_d.shd.fp       = cfg_wdata[FP_W-1:0];
                A_WIDTH:  s_d.shd.w        = cfg_wdata[DIM_W-1:0];
                A_HEIGHT: s_d.shd.h        = cfg_wdata[DIM_W-1:0];
                default: ;
            endcase
        end
        if (launch) begin
            s_d.act = s_d.shd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_mean  = s_q.act.mean;
    assign act_scale = s_q.act.scale;
    assign act_fp    = s_q.act.fp;
    assign act_w     = s_q.act.w;
    assign act_h     = s_q.act.h;
endmodule

// File: rtl/pix_norm_ctrl.sv
module pix_norm_ctrl
    import pix_norm_pkg::*;
#(
    parameter int DIM_W = 12,
    localparam int CNT_W = 2 * DIM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [DIM_W-1:0] act_w,
    input  logic [DIM_W-1:0] act_h,
    input  logic             in_valid,
    input  logic             out_ready,
    output logic             busy,
    output logic             launch,
    output logic             in_ready,
    output logic             stage_en,
    output logic             out_valid,
    output logic             done
);
    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  in_cnt;
        logic [CNT_W-1:0]  out_cnt;
        logic [STAGES-1:0] vld;
        logic              done;
    } ctrl_state_t;

    ctrl_state_t c_d, c_q;
    logic [CNT_W-1:0] total;
    logic in_fire, out_fire;

    always_comb begin
        total    = {{DIM_W{1'b0}}, act_w} * {{DIM_W{1'b0}}, act_h};
        stage_en = !c_q.vld[STAGES-1] || out_ready;
        in_ready = c_q.busy && (c_q.in_cnt != total) && stage_en;
        in_fire  = in_valid && in_ready;
        out_fire = c_q.vld[STAGES-1] && out_ready;
        launch   = start && !c_q.busy;

        c_d      = c_q;
        c_d.done = 1'b0;
        if (stage_en) begin
            c_d.vld = {c_q.vld[STAGES-2:0], in_fire};
        end
        if (in_fire) begin
            c_d.in_cnt = c_q.in_cnt + 1'b1;
        end
        if (out_fire) begin
            c_d.out_cnt = c_q.out_cnt + 1'b1;
            if (c_q.out_cnt == total - CNT_W'(1)) begin
                c_d.busy = 1'b0;
                c_d.done = 1'b1;
            end
        end
        if (launch) begin
            c_d.busy    = 1'b1;
            c_d.in_cnt  = '0;
            c_d.out_cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy      = c_q.busy;
    assign out_valid = c_q.vld[STAGES-1];
    assign done      = c_q.done;
endmodule

// File: rtl/pix_norm_lane.sv
module pix_norm_lane
    import pix_norm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic [PIX_W-1:0]   pix,
    input  logic [MEAN_W-1:0]  mean,
    input  logic [SCALE_W-1:0] scale,
    input  logic [FP_W-1:0]    fp,
    output logic [PIX_W-1:0]   res
);
    localparam logic signed [QUO_W-1:0] MAX_V = QUO_W'(127);
    localparam logic signed [QUO_W-1:0] MIN_V = -QUO_W'(128);

    typedef struct packed {
        logic signed [DIFF_W-1:0] diff;
        logic signed [PROD_W-1:0] prod;
        logic signed [QUO_W-1:0]  quo;
        logic signed [PIX_W-1:0]  res;
    } lane_state_t;

    lane_state_t l_d, l_q;
    logic signed [SHIFT_W-1:0] ext, shifted;
    logic        [SHIFT_W-1:0] bias, biased;

    always_comb begin
        // stage 1: offset removal in half-units
        l_d.diff = $signed({1'b0, pix, 1'b0}) - $signed({1'b0, mean});
        // stage 2: gain
        l_d.prod = l_q.diff * $signed({1'b0, scale});
        // stage 3: power-of-two factor and truncation toward zero
        ext      = {{(SHIFT_W-PROD_W){l_q.prod[PROD_W-1]}}, l_q.prod};
        shifted  = ext <<< fp;
        bias     = {{(SHIFT_W-DROP){1'b0}}, {DROP{shifted[SHIFT_W-1]}}};
        biased   = shifted + bias;
        l_d.quo  = biased[SHIFT_W-1:DROP];
        // stage 4: clamp to a signed byte
        if (l_q.quo > MAX_V) begin
            l_d.res = 8'sd127;
        end else if (l_q.quo < MIN_V) begin
            l_d.res = -8'sd128;
        end else begin
            l_d.res = l_q.quo[PIX_W-1:0];
        end
        if (!en) begin
            l_d = l_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            l_q <= '0;
        end else begin
            l_q <= l_d;
        end
    end

    assign res = l_q.res;
endmodule

// File: rtl/pix_norm_top.sv
module pix_norm_top
    import pix_norm_pkg::*;
#(
    parameter int DIM_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [CFG_DW-1:0]      cfg_wdata,
    input  logic                   start,
    output logic                   done,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NCH*PIX_W-1:0]   in_data,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NCH*PIX_W-1:0]   out_data
);
    logic                        busy, launch, stage_en;
    logic [NCH-1:0][MEAN_W-1:0]  act_mean;
    logic [NCH-1:0][SCALE_W-1:0] act_scale;
    logic [FP_W-1:0]             act_fp;
    logic [DIM_W-1:0]            act_w, act_h;

    pix_norm_cfg #(.DIM_W(DIM_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .busy(busy), .launch(launch),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .act_mean(act_mean), .act_scale(act_scale), .act_fp(act_fp),
        .act_w(act_w), .act_h(act_h)
    );

    pix_norm_ctrl #(.DIM_W(DIM_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .act_w(act_w), .act_h(act_h),
        .in_valid(in_valid), .out_ready(out_ready), .busy(busy), .launch(launch),
        .in_ready(in_ready), .stage_en(stage_en), .out_valid(out_valid), .done(done)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_lane
        pix_norm_lane u_lane (
            .clk(clk), .rst_n(rst_n), .en(stage_en),
            .pix(in_data[c*PIX_W +: PIX_W]),
            .mean(act_mean[c]), .scale(act_scale[c]), .fp(act_fp),
            .res(out_data[(NCH-1-c)*PIX_W +: PIX_W])
        );
    end
endmodule

// File: rtl/pix_norm_chk.sv
module pix_norm_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [23:0] out_data,
    input logic        done
);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    // R7
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid && in_ready, 4) && $past(out_ready, 1) &&
         $past(out_ready, 2) && $past(out_ready, 3)) |-> out_valid);
endmodule

bind pix_norm_top pix_norm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done)
);

// File: tb/test_pix_norm_top.sv
module test_pix_norm_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [16:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic        done;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [23:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [23:0] out_data;

    int checks = 0;
    int fails = 0;
    int bm [3];
    int bs [3];
    int bfp;
    logic [23:0] expq [$];

    pix_norm_top i_pix_norm_top (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .done(done),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish, actual hung expected finished");
        summary();
        $finish;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [7:0] ref_ch(input int p, input int m, input int s, input int f);
        longint d, v;
        d = 2 * p - m;
        v = (d * s * (longint'(1) << f)) / 131072;
        if (v > 127) v = 127;
        if (v < -128) v = -128;
        return 8'(v);
    endfunction

    function automatic logic [23:0] ref_pix(input logic [23:0] px);
        return {ref_ch(int'(px[7:0]), bm[0], bs[0], bfp),
                ref_ch(int'(px[15:8]), bm[1], bs[1], bfp),
                ref_ch(int'(px[23:16]), bm[2], bs[2], bfp)};
    endfunction

    task automatic cfg_write(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = 4'(a);
        cfg_wdata = 17'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_cfg(input int m0, input int m1, input int m2,
                           input int s0, input int s1, input int s2,
                           input int f, input int w, input int h);
        cfg_write(0, m0); cfg_write(1, m1); cfg_write(2, m2);
        cfg_write(3, s0); cfg_write(4, s1); cfg_write(5, s2);
        cfg_write(6, f);  cfg_write(7, w);  cfg_write(8, h);
        bm[0] = m0; bm[1] = m1; bm[2] = m2;
        bs[0] = s0; bs[1] = s1; bs[2] = s2;
        bfp = f;
    endtask

    function automatic logic [23:0] pick_pix(input int mode);
        logic [23:0] v;
        case (mode)
            0: v = 24'($urandom);
            1: for (int k = 0; k < 24; k += 8) v[k +: 8] = ($urandom % 2) ? 8'hFF : 8'h00;
            default: v = 24'h0A0A0A;
        endcase
        return v;
    endfunction

    // One frame with random valid/ready gaps; poke issues a register write and a start mid-frame.
    task automatic run_frame(input int w, input int h, input int pv, input int pr,
                             input int mode, input bit poke);
        int total, sent, got, it, early_done, r9_bad, r8_bad;
        bit hold;
        total = w * h; sent = 0; got = 0; it = 0; hold = 0;
        early_done = 0; r9_bad = 0; r8_bad = 0;
        expq.delete();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (got < total && it < 20000) begin
            if (!hold) begin
                if (sent < total && ($urandom % 100) < pv) begin
                    in_valid = 1'b1;
                    in_data = pick_pix(mode);
                    hold = 1;
                end else begin
                    in_valid = 1'b0;
                end
            end
            out_ready = (($urandom % 100) < pr);
            if (poke) begin
                cfg_we = (it == 3);
                cfg_addr = 4'd2;
                cfg_wdata = 17'd0;
                start = (it == 3);
            end
            #1;
            if (done) early_done++;
            if (sent == total && in_ready) r9_bad++;
            if (in_valid && in_ready) begin
                expq.push_back(ref_pix(in_data));
                sent++;
                hold = 0;
            end
            if (out_valid && expq.size() > 0) begin
                if (out_ready) begin
                    check(out_data == expq[0], "R2/R3/R4 result", int'(out_data), int'(expq[0]));
                    void'(expq.pop_front());
                    got++;
                end else if (out_data != expq[0]) begin
                    r8_bad++;
                end
            end
            @(negedge clk);
            it++;
        end
        cfg_we = 1'b0;
        start = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        check(got == total, "R8 all results delivered", got, total);
        check(r8_bad == 0, "R8 stalled output held", r8_bad, 0);
        check(r9_bad == 0, "R9/R6 in_ready after last pixel", r9_bad, 0);
        check(early_done == 0, "R10 no early done", early_done, 0);
        #1;
        check(done == 1'b1, "R10 done after last transfer", int'(done), 1);
        check(in_ready == 1'b0, "R10 idle after done", int'(in_ready), 0);
        @(negedge clk);
        #1;
        check(done == 1'b0, "R10 done one cycle", int'(done), 0);
    endtask

    initial begin
        int n;
        logic [23:0] px;
        repeat (3) @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R1 out_valid reset", int'(out_valid), 0);
        check(in_ready == 1'b0, "R1 in_ready reset", int'(in_ready), 0);
        check(done == 1'b0, "R1 done reset", int'(done), 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b1;
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        #1;
        check(in_ready == 1'b0, "R1 in_ready before start", int'(in_ready), 0);
        in_valid = 1'b0;
        out_ready = 1'b0;

        // R7 latency, offset-only mode
        set_cfg(208, 234, 246, 65536, 65536, 65536, 1, 1, 1);
        @(negedge clk);
        start = 1'b1;
        out_ready = 1'b1;
        @(negedge clk);
        start = 1'b0;
        px = 24'hC8_40_90;
        in_valid = 1'b1;
        in_data = px;
        #1;
        check(in_ready == 1'b1, "R7 pixel accepted", int'(in_ready), 1);
        n = 0;
        do begin
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            n++;
        end while (!out_valid && n < 10);
        check(n == 4, "R7 latency cycles", n, 4);
        check(out_data == ref_pix(px), "R7/R4 result", int'(out_data), int'(ref_pix(px)));
        @(negedge clk);
        out_ready = 1'b0;
        #1;
        check(done == 1'b1, "R10 single-pixel done", int'(done), 1);

        // offset-only mode, random pixels
        set_cfg(208, 234, 246, 65536, 65536, 65536, 1, 8, 4);
        run_frame(8, 4, 80, 100, 0, 0);

        // saturation: extremes with exponent 7, heavy stalls
        set_cfg(208, 234, 246, 65536, 65536, 65536, 7, 5, 4);
        run_frame(5, 4, 100, 30, 1, 0);

        // half-range offset, gain 1/127.5
        set_cfg(255, 255, 255, 514, 514, 514, 6, 6, 5);
        run_frame(6, 5, 50, 60, 0, 0);

        // R2 truncation toward zero: (20-21)*1.5*2/2 = -1.5 -> -1
        set_cfg(21, 21, 21, 98304, 98304, 98304, 1, 2, 2);
        run_frame(2, 2, 100, 100, 2, 0);
        px = ref_pix(24'h0A0A0A);
        check(px == 24'hFFFFFF, "R2 truncation model", int'(px), 24'hFFFFFF);

        // R5/R6: write and start mid-frame have no effect, next frame keeps latched values
        set_cfg(100, 60, 200, 70000, 40000, 90000, 2, 5, 2);
        run_frame(5, 2, 70, 70, 0, 1);
        run_frame(5, 2, 90, 90, 0, 0);

        // random settings
        for (int f = 0; f < 6; f++) begin
            int w, h;
            w = 1 + int'($urandom % 7);
            h = 1 + int'($urandom % 5);
            set_cfg(int'($urandom % 512), int'($urandom % 512), int'($urandom % 512),
                    int'($urandom % 131072), int'($urandom % 131072), int'($urandom % 131072),
                    1 + int'($urandom % 7), w, h);
            run_frame(w, h, 60, 60, f % 2, 0);
        end

        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
    end
endmodule